// File: doc/BRIEF.md
# Per-Line Edge Event Interrupt Unit

This block watches a bank of already synchronized input lines and records edges on them. Each line has its own edge-direction bit and its own enable bit. When an enabled line shows an edge in its selected direction, the block sets that line's bit in a sticky event register. The host reads this register to learn which lines fired.

The event bits are also ORed into a coarse pending field with one bit per group of eight lines. A single level-sensitive, active-high interrupt request is raised while any event is held. The host clears events by writing the event register. A bit written as zero is cleared, and a bit written as one is kept, so writing all zeros clears every event.

An edge is judged only by comparing two consecutive samples of the true line level. This means that reprogramming a line's direction does not create a false event. The first sample after reset is only a reference and creates no event.

Top module: `edge_irq_unit`

## Requirements
- R1: While reset is asserted and directly after it, the event register, the pending field and the interrupt request are all zero.
- R2: When a line's direction bit is 1 and its enable bit is 1, a low-to-high change between two consecutive samples sets that line's event bit. The bit is visible on the clock after the edge that captures the high sample.
- R3: When a line's direction bit is 0 and its enable bit is 1, a high-to-low change between two consecutive samples sets that line's event bit, with the same timing as R2.
- R4: A change in the direction not selected by a line's direction bit leaves its event bit unchanged.
- R5: A line whose enable bit is 0 never sets its event bit. When all enable bits are 0, no new events are recorded.
- R6: An event bit stays set until a host write clears it.
- R7: When the write strobe is high, each event bit whose write-data bit is 0 is cleared, and each event bit whose write-data bit is 1 is kept. Writing all zeros clears all events.
- R8: If a qualifying edge lands in the same cycle as a write that clears its bit, the bit ends up set.
- R9: Pending bit k is the OR of event bits 8k through 8k+7, so bit 0 covers lines 0–7, bit 1 covers lines 8–15 and bit 2 covers lines 16–23.
- R10: The interrupt request is high exactly when the pending field is nonzero.
- R11: Changing direction bits while the line levels stay steady records no event.
- R12: The first sample taken after reset creates no event, whatever the line levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_lvl | input | 24 | Synchronized true levels of the watched lines |
| edge_dir | input | 24 | Per-line direction: 1 rising, 0 falling |
| edge_en | input | 24 | Per-line event enable |
| evt_wr | input | 1 | Event register write strobe |
| evt_wdata | input | 24 | Write data: 0 clears that bit, 1 keeps it |
| evt_id | output | 24 | Sticky per-line event register |
| evt_pend | output | 3 | Per-group OR of the event register |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The hardest case to reach from the ports is the collision between a host clear and a fresh edge on the same line in the same cycle. The stimulus reaches it by arming a falling-edge line and then, in one cycle, dropping its level while the strobe writes all zeros. It then checks that the bit survives while the other bits clear. A second hard case is a reset released with lines held high, followed by direction flips at steady levels. This shows that no event comes from history or from reprogramming.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  // Default geometry of the watched bank
  localparam int unsigned DEF_LINES = 24;
  localparam int unsigned DEF_GROUP = 8;

  // One line qualifies when consecutive samples differ in the chosen sense
  function automatic logic edge_qualifies(input logic now_lvl,
                                          input logic old_lvl,
                                          input logic dir_rise);
    logic rose;
    logic fell;
    rose = now_lvl & ~old_lvl;
    fell = ~now_lvl & old_lvl;
    return dir_rise ? rose : fell;
  endfunction

  // Next value of one event bit: clear by zero write, new hit always wins
  function automatic logic evt_next(input logic cur,
                                    input logic wr,
                                    input logic keep,
                                    input logic hit);
    logic held;
    held = wr ? (cur & keep) : cur;
    return held | hit;
  endfunction
endpackage

// File: rtl/edge_line_sampler.sv
module edge_line_sampler
  import edge_irq_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_lvl,
  input  logic [LINES-1:0] edge_dir,
  input  logic [LINES-1:0] edge_en,
  output logic [LINES-1:0] line_hit
);
  logic [LINES-1:0] prev_lvl;
  logic             prev_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lvl <= '0;
      prev_ok  <= 1'b0;
    end else begin
      prev_lvl <= line_lvl;
      prev_ok  <= 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line_hit[i] = prev_ok & edge_en[i] &
                         edge_qualifies(line_lvl[i], prev_lvl[i], edge_dir[i]);
  end
endmodule

// File: rtl/event_id_reg.sv
module event_id_reg
  import edge_irq_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_hit,
  input  logic             evt_wr,
  input  logic [LINES-1:0] evt_wdata,
  output logic [LINES-1:0] evt_id
);
  logic [LINES-1:0] id_d;

  for (genvar i = 0; i < LINES; i++) begin : g_bit
    assign id_d[i] = evt_next(evt_id[i], evt_wr, evt_wdata[i], line_hit[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt_id <= '0;
    else        evt_id <= id_d;
  end
endmodule

// File: rtl/pend_reduce.sv
module pend_reduce
  import edge_irq_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES,
  parameter int unsigned GROUP = DEF_GROUP,
  localparam int unsigned GROUPS = (LINES + GROUP - 1) / GROUP
) (
  input  logic [LINES-1:0]  evt_id,
  output logic [GROUPS-1:0] evt_pend
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int unsigned LO = g * GROUP;
    localparam int unsigned HI = ((g + 1) * GROUP > LINES) ? LINES - 1 : (g + 1) * GROUP - 1;
    assign evt_pend[g] = |evt_id[HI:LO];
  end
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int unsigned LINES = DEF_LINES,
  parameter int unsigned GROUP = DEF_GROUP,
  localparam int unsigned GROUPS = (LINES + GROUP - 1) / GROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line_lvl,
  input  logic [LINES-1:0]  edge_dir,
  input  logic [LINES-1:0]  edge_en,
  input  logic              evt_wr,
  input  logic [LINES-1:0]  evt_wdata,
  output logic [LINES-1:0]  evt_id,
  output logic [GROUPS-1:0] evt_pend,
  output logic              irq
);
  // Qualified per-line edge this cycle, named for the checker
  logic [LINES-1:0] line_hit;

  edge_line_sampler #(.LINES(LINES)) u_samp (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl),
    .edge_dir(edge_dir), .edge_en(edge_en), .line_hit(line_hit)
  );

  event_id_reg #(.LINES(LINES)) u_id (
    .clk(clk), .rst_n(rst_n), .line_hit(line_hit),
    .evt_wr(evt_wr), .evt_wdata(evt_wdata), .evt_id(evt_id)
  );

  pend_reduce #(.LINES(LINES), .GROUP(GROUP)) u_pend (
    .evt_id(evt_id), .evt_pend(evt_pend)
  );

  assign irq = |evt_id;
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int unsigned LINES  = 24,
  parameter int unsigned GROUPS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINES-1:0]  line_lvl,
  input logic [LINES-1:0]  edge_en,
  input logic              evt_wr,
  input logic [LINES-1:0]  line_hit,
  input logic [LINES-1:0]  evt_id,
  input logic [GROUPS-1:0] evt_pend,
  input logic              irq
);
  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_id & ~$past(evt_id) & ~$past(edge_en)) == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr |=> (($past(evt_id) & ~evt_id) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr |=> ((evt_id & $past(line_hit)) == $past(line_hit)));

  // R10
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (evt_pend != '0));

  // R11
  needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_id & ~$past(evt_id) & ~($past(line_lvl, 1) ^ $past(line_lvl, 2))) == '0));
endmodule

bind edge_irq_unit edge_irq_chk #(.LINES(LINES), .GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .edge_en(edge_en),
  .evt_wr(evt_wr), .line_hit(line_hit), .evt_id(evt_id),
  .evt_pend(evt_pend), .irq(irq)
);

// File: tb/edge_irq_unit_bench.sv
module edge_irq_unit_bench;
  localparam int N = 24;
  localparam int G = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] line_lvl, edge_dir, edge_en, evt_wdata;
  logic         evt_wr;
  logic [N-1:0] evt_id;
  logic [G-1:0] evt_pend;
  logic         irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  edge_irq_unit u_edge_irq_unit (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .edge_dir(edge_dir),
    .edge_en(edge_en), .evt_wr(evt_wr), .evt_wdata(evt_wdata),
    .evt_id(evt_id), .evt_pend(evt_pend), .irq(irq)
  );

  typedef struct {
    logic [N-1:0] id;
    logic [G-1:0] pend;
    logic         rq;
    string        tag;
  } exp_t;

  exp_t sb[$];

  // Reference model state
  logic [N-1:0] m_prev;
  bit           m_ok;
  logic [N-1:0] m_id;

  function automatic logic [G-1:0] m_pend(input logic [N-1:0] v);
    logic [G-1:0] p = '0;
    for (int i = 0; i < N; i++) if (v[i]) p[i / 8] = 1'b1;
    return p;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] id, input logic [G-1:0] pd,
                       input logic rq);
    total++;
    if (evt_id !== id || evt_pend !== pd || irq !== rq) begin
      bad++;
      $display("FAIL %s: got id=%h pend=%b irq=%b, want id=%h pend=%b irq=%b",
               tag, evt_id, evt_pend, irq, id, pd, rq);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic [N-1:0] lv, input logic [N-1:0] dir,
                      input logic [N-1:0] en, input logic wr,
                      input logic [N-1:0] wd, input string tag);
    exp_t e;
    logic [N-1:0] nid;
    @(negedge clk);
    line_lvl = lv; edge_dir = dir; edge_en = en; evt_wr = wr; evt_wdata = wd;
    nid = m_id;
    if (wr) nid = nid & wd;
    for (int i = 0; i < N; i++) begin
      if (m_ok && en[i]) begin
        if (dir[i] && lv[i] && !m_prev[i]) nid[i] = 1'b1;
        if (!dir[i] && !lv[i] && m_prev[i]) nid[i] = 1'b1;
      end
    end
    m_id = nid; m_prev = lv; m_ok = 1'b1;
    e.id = nid; e.pend = m_pend(nid); e.rq = (nid != '0); e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, e.id, e.pend, e.rq);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [N-1:0] ALL = '1;

  initial begin
    logic [N-1:0] lv;
    rst_n = 1'b0; line_lvl = ALL; edge_dir = ALL; edge_en = ALL;
    evt_wr = 1'b0; evt_wdata = '0;
    m_prev = '0; m_ok = 1'b0; m_id = '0;
    repeat (3) @(posedge clk);
    #2 check("R1 reset", '0, '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 after reset", '0, '0, 1'b0);
    // R12: lines already high at first sample
    step(ALL, ALL, ALL, 1'b0, '0, "R12 first sample");
    step(ALL, ALL, ALL, 1'b0, '0, "R12 steady");
    // R4: falling edge on line 3 with rising selected
    lv = ALL; lv[3] = 1'b0;
    step(lv, ALL, ALL, 1'b0, '0, "R4 wrong direction");
    // R2: rising edge on line 3
    lv[3] = 1'b1;
    step(lv, ALL, ALL, 1'b0, '0, "R2 rising");
    step(lv, ALL, ALL, 1'b0, '0, "R6 held");
    step(lv, ALL, ALL, 1'b0, '0, "R6 held again");
    // R3: falling on line 10 with falling selected
    lv[10] = 1'b0;
    step(lv, ALL & ~(24'h1 << 10), ALL, 1'b0, '0, "R3 falling R9 group1");
    // R5: line 20 disabled, rising edge ignored
    lv[20] = 1'b0;
    step(lv, ALL, ALL, 1'b0, '0, "R5 setup");
    lv[20] = 1'b1;
    step(lv, ALL, ALL & ~(24'h1 << 20), 1'b0, '0, "R5 disabled line");
    // R5: all enables off, many changes
    step(~lv, 24'h000000, '0, 1'b0, '0, "R5 all off fall");
    step(lv, ALL, '0, 1'b0, '0, "R5 all off rise");
    // R7: keep line 3 only
    step(lv, ALL, ALL, 1'b1, 24'h000008, "R7 partial clear");
    step(lv, ALL, ALL, 1'b1, '0, "R7 clear all R10");
    // R11: flip directions with levels steady
    step(lv, '0, ALL, 1'b0, '0, "R11 dir flip");
    step(lv, ALL, ALL, 1'b0, '0, "R11 dir flip back");
    // R8: falling on line 17 coincident with clear-all write
    step(lv, '0, ALL, 1'b0, '0, "R8 arm");
    lv[17] = 1'b0;
    step(lv, '0, ALL, 1'b1, '0, "R8 set wins R9 group2");
    // R9: hit in every group
    lv[0] = 1'b0; lv[15] = 1'b0;
    step(lv, '0, ALL, 1'b0, '0, "R9 all groups");
    step(lv, '0, ALL, 1'b1, 24'h008000, "R9 group1 only");
    step(lv, '0, ALL, 1'b1, '0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule